// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block recovers characters from an asynchronous serial line. A line-rate tick at sixteen times the bit rate (the `OS_RATE` parameter) comes from outside. While reception is enabled, the receiver watches for a falling edge. It confirms the start bit at the middle of that bit and then takes one sample near the middle of every following bit. Each frame carries 7, 8 or 9 data bits, an optional parity bit and one or two stop bits. A completed character moves into a single-entry receive buffer, and a one-cycle interrupt pulse marks the transfer.

The buffer holds three error flags: overrun, framing and parity. An error-sum output is high whenever any of the three is high. A read strobe empties the buffer and clears all flags. The receiver can also:
- accept characters most-significant bit first;
- complement the data and parity bits alone, or the whole line;
- drive a ready-to-send output that tells the far end whether the buffer has room.

Top module: `serial_rx_frame`

## Requirements
- R1: While `rx_en` is low the receiver stays idle, detects no start bit and loads nothing; a frame sent on the line in that time leaves every output unchanged.
- R2: Each bit is taken on the 8th tick counted from the tick that first sees the line low. When the final stop bit is sampled, the character is loaded into `rx_data` right-aligned, with zeros above the configured length. At the same time `rx_full` goes high and `rx_irq` is high for exactly one clock. `char_len` encodes the length: 0 = 7 bits, 1 = 8, 2 = 9, 3 = 8.
- R3: If `rx_full` is still high when the bit just before the final stop bit is sampled, `ovr_err` is set. That frame is then discarded: `rx_data` keeps its old value and no interrupt is raised.
- R4: `frm_err` is loaded high with a character if any configured stop bit (`two_stop` = 1 selects two) was sampled low.
- R5: With `par_en` high, `par_err` is loaded high when the data bits and the parity bit together hold an odd number of ones (`par_odd` = 0) or an even number (`par_odd` = 1).
- R6: `err_any` equals the OR of the three error flags. A `rd_stb` pulse clears `rx_full` and all error flags and leaves `rx_data` as it was.
- R7: With `msb_first` low, the first data bit received lands in bit 0. With it high, the first data bit lands in bit `len-1`.
- R8: With `data_inv` high, the data and parity bits arrive complemented and are restored before use; start and stop bits keep their normal levels.
- R9: With `line_inv` high, every level on `rxd` is complemented, idle included.
- R10: `rts_out` is high while `rts_en` is high and the buffer is full. It is low when the buffer is empty or `rts_en` is low.
- R11: A start bit that is high again at its sampling point is dropped. The receiver returns to idle and nothing is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line input |
| os_tick | input | 1 | One-cycle pulse at the oversampling rate |
| rx_en | input | 1 | Reception enable |
| char_len | input | 2 | Character length select |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when high, even when low |
| two_stop | input | 1 | Two stop bits when high |
| msb_first | input | 1 | First data bit is the most significant |
| data_inv | input | 1 | Data and parity bits are complemented on the line |
| line_inv | input | 1 | Whole line is complemented |
| rts_en | input | 1 | Enables the ready-to-send output |
| rd_stb | input | 1 | Buffer read strobe |
| rx_data | output | DATA_W | Receive buffer contents |
| rx_full | output | 1 | Buffer holds an unread character |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| err_any | output | 1 | Error-sum flag |
| rts_out | output | 1 | Ready-to-send, high while buffer full |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
A drifting oversample counter or a miscounted field index moves the sampling point or the frame's end. The load and the interrupt pulse then arrive on the wrong clock, and the bench compares every clock, so it sees this within one tick period. A wrong bit slot or ordering corrupts `rx_data` at the load of that frame. A stale per-frame overrun marker shows up on the next frame as a missing load, or as a load where an overrun should have kept the old data. A flag register that keeps its value past a read shows at `err_any` on the clock after the strobe.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   typedef struct packed {
      logic ovr;
      logic frm;
      logic par;
   } err_flags_t;

   // length select: 0 -> 7, 2 -> 9, otherwise 8
   function automatic logic [3:0] char_bits(input logic [1:0] sel);
      case (sel)
         2'd0:    char_bits = 4'd7;
         2'd2:    char_bits = 4'd9;
         default: char_bits = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/srx_line_cond.sv
module srx_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd,
   input  logic line_inv,
   output logic rx_bit
);

   logic lvl;
   assign lvl = rxd ^ line_inv;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign rx_bit = lvl;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain[0] <= lvl;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  chain[k] <= chain[k-1];
               end
            end
         end
         assign rx_bit = chain[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_bit_engine.sv
module srx_bit_engine
   import srx_pkg::*;
#(
   parameter int OS_RATE = 16,
   parameter int DATA_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bit,
   input  logic              os_tick,
   input  logic              rx_en,
   input  logic [1:0]        char_len,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              msb_first,
   input  logic              data_inv,
   output logic              busy,
   output logic              pre_last,
   output logic              frame_done,
   output logic [DATA_W-1:0] frame_char,
   output logic              frame_fe,
   output logic              frame_pe
);

   localparam int CNT_W = $clog2(OS_RATE);
   localparam int MID   = OS_RATE / 2 - 1;
   localparam int LAST  = OS_RATE - 1;
   localparam int FLD_W = $clog2(DATA_W + 1);
   localparam int IDX_W = $clog2(DATA_W);

   rx_state_e         state;
   logic [CNT_W-1:0]  os_cnt;
   logic [FLD_W-1:0]  fld_cnt;
   logic [DATA_W-1:0] shreg;
   logic              par_acc;
   logic              fe_acc;

   logic [FLD_W-1:0]  len;
   logic              at_mid, at_end, bit_val, is_last, is_prelast, samp;

   assign len     = FLD_W'(char_bits(char_len));
   assign at_mid  = (os_cnt == CNT_W'(MID));
   assign at_end  = (os_cnt == CNT_W'(LAST));
   assign bit_val = rx_bit ^ data_inv;
   assign samp    = os_tick && (state != RX_IDLE) && at_mid;
   assign busy    = (state != RX_IDLE);

   assign is_last = (state == RX_STOP) && (fld_cnt == FLD_W'(two_stop));

   always_comb begin
      if (two_stop) begin
         is_prelast = (state == RX_STOP) && (fld_cnt == '0);
      end else begin
         is_prelast = (state == RX_PAR) ||
                      ((state == RX_DATA) && !par_en && (fld_cnt == len - 1'b1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         os_cnt  <= '0;
         fld_cnt <= '0;
         shreg   <= '0;
         par_acc <= 1'b0;
         fe_acc  <= 1'b0;
      end else if (!rx_en) begin
         state  <= RX_IDLE;
         os_cnt <= '0;
      end else if (os_tick) begin
         if (state == RX_IDLE) begin
            if (!rx_bit) begin
               state   <= RX_START;
               os_cnt  <= CNT_W'(1);
               fld_cnt <= '0;
               par_acc <= 1'b0;
               fe_acc  <= 1'b0;
            end
         end else begin
            os_cnt <= at_end ? '0 : os_cnt + 1'b1;
            if (at_mid) begin
               case (state)
                  RX_START: if (rx_bit) state <= RX_IDLE;
                  RX_DATA: begin
                     shreg[IDX_W'(fld_cnt)] <= bit_val;
                     par_acc <= par_acc ^ bit_val;
                  end
                  RX_PAR: par_acc <= par_acc ^ bit_val;
                  RX_STOP: begin
                     if (!rx_bit) fe_acc <= 1'b1;
                     if (is_last) state <= RX_IDLE;
                  end
                  default: ;
               endcase
            end
            if (at_end) begin
               case (state)
                  RX_START: begin
                     state   <= RX_DATA;
                     fld_cnt <= '0;
                  end
                  RX_DATA: begin
                     if (fld_cnt == len - 1'b1) begin
                        state   <= par_en ? RX_PAR : RX_STOP;
                        fld_cnt <= '0;
                     end else begin
                        fld_cnt <= fld_cnt + 1'b1;
                     end
                  end
                  RX_PAR: begin
                     state   <= RX_STOP;
                     fld_cnt <= '0;
                  end
                  RX_STOP: fld_cnt <= fld_cnt + 1'b1;
                  default: ;
               endcase
            end
         end
      end
   end

   assign frame_done = samp && is_last;
   assign pre_last   = samp && is_prelast;
   assign frame_fe   = fe_acc | ~rx_bit;
   assign frame_pe   = par_en & (par_acc ^ par_odd);

   // place arrival-ordered bits into the character, masked to its length
   always_comb begin
      frame_char = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(len)) begin
            if (msb_first) begin
               frame_char[i] = shreg[IDX_W'(int'(len) - 1 - i)];
            end else begin
               frame_char[i] = shreg[i];
            end
         end
      end
   end

endmodule

// File: rtl/srx_rx_buffer.sv
module srx_rx_buffer
   import srx_pkg::*;
#(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done,
   input  logic [DATA_W-1:0] frame_char,
   input  logic              frame_fe,
   input  logic              frame_pe,
   input  logic              pre_last,
   input  logic              busy,
   input  logic              rd_stb,
   input  logic              rts_en,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              ovr_err,
   output logic              frm_err,
   output logic              par_err,
   output logic              err_any,
   output logic              rx_irq,
   output logic              rts_out
);

   logic [DATA_W-1:0] data_q, data_n;
   logic              full_q, full_n;
   err_flags_t        flags_q, flags_n;
   logic              sum_q, irq_q, frame_ovr_q;
   logic              load, ovr_hit;

   assign ovr_hit = pre_last & full_q;
   assign load    = frame_done & ~frame_ovr_q;

   always_comb begin
      data_n  = data_q;
      full_n  = full_q;
      flags_n = flags_q;
      if (load) begin
         data_n      = frame_char;
         full_n      = 1'b1;
         flags_n.frm = frame_fe;
         flags_n.par = frame_pe;
      end else if (rd_stb) begin
         full_n  = 1'b0;
         flags_n = '0;
      end
      if (ovr_hit) flags_n.ovr = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q      <= '0;
         full_q      <= 1'b0;
         flags_q     <= '0;
         sum_q       <= 1'b0;
         irq_q       <= 1'b0;
         frame_ovr_q <= 1'b0;
      end else begin
         data_q      <= data_n;
         full_q      <= full_n;
         flags_q     <= flags_n;
         sum_q       <= |flags_n;
         irq_q       <= load;
         frame_ovr_q <= busy ? (frame_ovr_q | ovr_hit) : 1'b0;
      end
   end

   assign rx_data = data_q;
   assign rx_full = full_q;
   assign ovr_err = flags_q.ovr;
   assign frm_err = flags_q.frm;
   assign par_err = flags_q.par;
   assign err_any = sum_q;
   assign rx_irq  = irq_q;
   assign rts_out = rts_en & full_q;

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame #(
   parameter int OS_RATE     = 16,
   parameter int DATA_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              os_tick,
   input  logic              rx_en,
   input  logic [1:0]        char_len,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              msb_first,
   input  logic              data_inv,
   input  logic              line_inv,
   input  logic              rts_en,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              ovr_err,
   output logic              frm_err,
   output logic              par_err,
   output logic              err_any,
   output logic              rts_out,
   output logic              rx_irq
);

   initial begin
      assert (OS_RATE >= 4 && OS_RATE % 2 == 0)
         else $error("OS_RATE must be even and at least 4");
      assert (DATA_W >= 9)
         else $error("DATA_W must hold a 9-bit character");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
   end

   logic              rx_bit;
   logic              eng_busy, pre_last, frame_done, frame_fe, frame_pe;
   logic [DATA_W-1:0] frame_char;

   srx_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .rxd      (rxd),
      .line_inv (line_inv),
      .rx_bit   (rx_bit)
   );

   srx_bit_engine #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_bit     (rx_bit),
      .os_tick    (os_tick),
      .rx_en      (rx_en),
      .char_len   (char_len),
      .par_en     (par_en),
      .par_odd    (par_odd),
      .two_stop   (two_stop),
      .msb_first  (msb_first),
      .data_inv   (data_inv),
      .busy       (eng_busy),
      .pre_last   (pre_last),
      .frame_done (frame_done),
      .frame_char (frame_char),
      .frame_fe   (frame_fe),
      .frame_pe   (frame_pe)
   );

   srx_rx_buffer #(.DATA_W(DATA_W)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .frame_char (frame_char),
      .frame_fe   (frame_fe),
      .frame_pe   (frame_pe),
      .pre_last   (pre_last),
      .busy       (eng_busy),
      .rd_stb     (rd_stb),
      .rts_en     (rts_en),
      .rx_data    (rx_data),
      .rx_full    (rx_full),
      .ovr_err    (ovr_err),
      .frm_err    (frm_err),
      .par_err    (par_err),
      .err_any    (err_any),
      .rx_irq     (rx_irq),
      .rts_out    (rts_out)
   );

endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
   parameter int DATA_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              rd_stb,
   input logic              rts_en,
   input logic              busy,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_full,
   input logic              ovr_err,
   input logic              frm_err,
   input logic              par_err,
   input logic              err_any,
   input logic              rx_irq,
   input logic              rts_out
);

   // R1
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !busy);

   // R2
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

   // R2
   irq_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_full);

   // R3
   overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> ($stable(rx_data) && !rx_irq));

   // R6
   err_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_any == (ovr_err | frm_err | par_err));

   // R6
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !busy) |=> (!rx_full && !err_any));

   // R10
   rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rts_en || !rx_full) |-> !rts_out);

endmodule

bind serial_rx_frame srx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rx_en   (rx_en),
   .rd_stb  (rd_stb),
   .rts_en  (rts_en),
   .busy    (eng_busy),
   .rx_data (rx_data),
   .rx_full (rx_full),
   .ovr_err (ovr_err),
   .frm_err (frm_err),
   .par_err (par_err),
   .err_any (err_any),
   .rx_irq  (rx_irq),
   .rts_out (rts_out)
);

// File: tb/serial_rx_frame_bench.sv
`timescale 1ns/1ps
module serial_rx_frame_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       os_tick = 1'b0;
   logic       rx_en = 1'b1;
   logic [1:0] char_len = 2'd1;
   logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
   logic       msb_first = 1'b0, data_inv = 1'b0, line_inv = 1'b0;
   logic       rts_en = 1'b0, rd_stb = 1'b0;
   logic [8:0] rx_data;
   logic       rx_full, ovr_err, frm_err, par_err, err_any, rts_out, rx_irq;

   always #2 clk = ~clk;

   serial_rx_frame u_serial_rx_frame (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .rx_en(rx_en),
      .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
      .msb_first(msb_first), .data_inv(data_inv), .line_inv(line_inv),
      .rts_en(rts_en), .rd_stb(rd_stb), .rx_data(rx_data), .rx_full(rx_full),
      .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err), .err_any(err_any),
      .rts_out(rts_out), .rx_irq(rx_irq)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // reference state
   int m_data = 0;
   bit m_full = 0, m_ovr = 0, m_frm = 0, m_par = 0, m_irq = 0, m_fr_ovr = 0;
   bit ev_pre = 0, ev_done = 0, ev_rd = 0;
   int p_char = 0;
   bit p_fe = 0, p_pe = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R2 rx_data", int'(rx_data), m_data);
      chk("R2 rx_full", int'(rx_full), int'(m_full));
      chk("R2 rx_irq", int'(rx_irq), int'(m_irq));
      chk("R3 ovr_err", int'(ovr_err), int'(m_ovr));
      chk("R4 frm_err", int'(frm_err), int'(m_frm));
      chk("R5 par_err", int'(par_err), int'(m_par));
      chk("R6 err_any", int'(err_any), int'(m_ovr | m_frm | m_par));
      chk("R10 rts_out", int'(rts_out), int'(rts_en & m_full));
   endtask

   task automatic step();
      @(negedge clk);
      if (ev_pre && m_full) begin
         m_ovr = 1;
         m_fr_ovr = 1;
      end
      if (ev_done) begin
         if (!m_fr_ovr) begin
            m_data = p_char; m_full = 1; m_frm = p_fe; m_par = p_pe; m_irq = 1;
         end
         m_fr_ovr = 0;
      end
      if (ev_rd) begin
         m_full = 0; m_ovr = 0; m_frm = 0; m_par = 0;
      end
      ev_pre = 0; ev_done = 0; ev_rd = 0;
      compare();
      m_irq = 0;
   endtask

   task automatic slot(input bit val, input bit pre, input bit done);
      rxd = val ^ line_inv;
      os_tick = 1'b1;
      ev_pre = pre;
      ev_done = done;
      step();
      os_tick = 1'b0;
      step(); step(); step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) slot(1'b1, 1'b0, 1'b0);
   endtask

   task automatic rd();
      rd_stb = 1'b1;
      ev_rd = 1;
      step();
      rd_stb = 1'b0;
      step();
   endtask

   // bad_stop: 0 none, k = k-th stop bit driven low across its centre
   task automatic send(input int c, input bit bad_par, input int bad_stop);
      int len, nb, ns, ones;
      int bits[16];
      bit d, p, v, acc;
      len = (char_len == 2'd0) ? 7 : (char_len == 2'd2) ? 9 : 8;
      ns = two_stop ? 2 : 1;
      nb = 0;
      ones = 0;
      bits[nb] = 0; nb++;
      for (int k = 0; k < len; k++) begin
         d = msb_first ? c[len-1-k] : c[k];
         ones += int'(d);
         bits[nb] = int'(d ^ data_inv); nb++;
      end
      if (par_en) begin
         p = bit'(ones % 2) ^ par_odd ^ bad_par;
         bits[nb] = int'(p ^ data_inv); nb++;
      end
      for (int s = 0; s < ns; s++) begin
         bits[nb] = (bad_stop == s + 1) ? 0 : 1; nb++;
      end
      p_char = c & ((1 << len) - 1);
      p_fe = (bad_stop != 0);
      p_pe = par_en & bad_par;
      acc = rx_en;
      for (int s = 0; s < 16 * nb; s++) begin
         v = bit'(bits[s / 16]);
         if ((s / 16) >= nb - ns && !v && (s % 16) >= 10) v = 1'b1;
         slot(v, acc && (s == 16 * (nb - 2) + 8), acc && (s == 16 * (nb - 1) + 8));
      end
      idle(20);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state: R2 R6 R10
      chk("R2 reset rx_full", int'(rx_full), 0);
      chk("R6 reset err_any", int'(err_any), 0);
      chk("R10 reset rts_out", int'(rts_out), 0);
      rst_n = 1'b1;
      step();
      idle(4);

      // R2: 8 data, no parity, one stop
      send(9'h0A5, 0, 0);
      chk("R2 8N1 char", int'(rx_data), 'hA5);
      rd();
      chk("R6 read clears full", int'(rx_full), 0);

      // R2 R5: 7 data, even parity, two stops, upper bits masked
      char_len = 2'd0; par_en = 1; par_odd = 0; two_stop = 1;
      send(9'h1DA, 0, 0);
      chk("R2 7-bit masked", int'(rx_data), 'h5A);
      chk("R5 good even parity", int'(par_err), 0);
      rd();

      // R5: 9 data, odd parity, good then bad
      char_len = 2'd2; par_odd = 1; two_stop = 0;
      send(9'h1C3, 0, 0);
      chk("R5 9-bit odd ok", int'(rx_data), 'h1C3);
      rd();
      send(9'h0F0, 1, 0);
      chk("R5 odd parity error", int'(par_err), 1);
      chk("R6 err_any on parity", int'(err_any), 1);
      rd();
      chk("R6 read clears par", int'(err_any), 0);

      // R4: 8 data even parity two stops, second stop low; then first low
      char_len = 2'd1; par_odd = 0; two_stop = 1;
      send(9'h03C, 0, 2);
      chk("R4 second stop low", int'(frm_err), 1);
      rd();
      send(9'h081, 0, 1);
      chk("R4 first stop low", int'(frm_err), 1);
      rd();

      // R7: msb first
      par_en = 0; two_stop = 0; msb_first = 1;
      send(9'h031, 0, 0);
      chk("R7 msb-first char", int'(rx_data), 'h31);
      rd();
      char_len = 2'd0;
      send(9'h045, 0, 0);
      chk("R7 msb-first 7-bit", int'(rx_data), 'h45);
      rd();
      msb_first = 0; char_len = 2'd1;

      // R8: data inversion with parity
      data_inv = 1; par_en = 1;
      send(9'h0C6, 0, 0);
      chk("R8 inverted data", int'(rx_data), 'hC6);
      chk("R8 parity after inversion", int'(par_err), 0);
      rd();

      // R9: line polarity inverted, with and without data inversion
      line_inv = 1; rxd = 1'b0; step(); step();
      send(9'h05B, 0, 0);
      chk("R9 line inv + data inv", int'(rx_data), 'h5B);
      rd();
      data_inv = 0; par_en = 0;
      send(9'h0E7, 0, 0);
      chk("R9 line inv only", int'(rx_data), 'hE7);
      rd();
      line_inv = 0; rxd = 1'b1; step(); step();

      // R3 R10: overrun with flow control enabled
      rts_en = 1;
      send(9'h011, 0, 0);
      chk("R10 rts high when full", int'(rts_out), 1);
      send(9'h022, 0, 0);
      chk("R3 overrun flag", int'(ovr_err), 1);
      chk("R3 data kept", int'(rx_data), 'h11);
      rd();
      chk("R10 rts low after read", int'(rts_out), 0);
      send(9'h033, 0, 0);
      chk("R3 next frame loads", int'(rx_data), 'h33);
      rts_en = 0; step();
      chk("R10 rts low when disabled", int'(rts_out), 0);
      rd();

      // R11: glitch start rejected, then a clean frame
      for (int i = 0; i < 4; i++) slot(1'b0, 0, 0);
      idle(30);
      chk("R11 glitch not loaded", int'(rx_full), 0);
      send(9'h07E, 0, 0);
      chk("R11 frame after glitch", int'(rx_data), 'h7E);
      rd();

      // R1: receive disabled
      rx_en = 0;
      send(9'h0AA, 0, 0);
      chk("R1 disabled no load", int'(rx_full), 0);
      chk("R1 disabled data kept", int'(rx_data), 'h7E);
      rx_en = 1; step();
      send(9'h055, 0, 0);
      chk("R1 re-enabled load", int'(rx_data), 'h55);
      rd();

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule